// File: doc/BRIEF.md
# Serial Receive Path with Error-Tagged Character Queue

This block is the receive half of an asynchronous serial port. It oversamples the incoming line with a tick that runs at sixteen times the bit rate and rebuilds each character: a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Each finished character goes into a receive queue together with three error tags: framing, parity and break. Because the tags travel through the queue with their own character, the errors that software sees always belong to the character it is about to read.

The block also keeps the receive-side line status bits. The framing, parity and break bits describe the character at the head of the queue. A status-read strobe clears them, and the overrun flag and the queue-error summary follow their own rules, given below. A pop strobe removes the head character. When queue mode is disabled, the queue holds one character.

Top module: `uart_rx_errfifo`

## Requirements
- R1: The line is sampled 8 ticks after the first tick that sees it low, and then every 16 ticks. If the line is high at that mid-start sample, the start is dropped as a glitch and nothing is received.
- R2: A character is start, 8 data bits LSB first, an even-parity bit and a stop bit. It appears at `head_data_o` with `head_valid_o` high two clock cycles after the tick that samples its stop bit.
- R3: The parity tag is set when the data bits and the parity bit hold an odd number of ones.
- R4: The framing tag is set when the sampled stop bit is 0. The receiver then treats that low stop bit as the start of the next character: the next data bit is sampled 16 ticks later, with no return to high required.
- R5: A character whose start, data, parity and stop samples are all 0 is a break. It is stored as one 0x00 character with only its break tag set, and the receiver then ignores the line until it samples a 1.
- R6: `stat_frame_o`, `stat_parity_o` and `stat_break_o` show the tags of the head character. A status read clears them. A character that becomes the head in the same cycle as a read shows its tags. All three are 0 while the queue is empty.
- R7: In queue mode the queue holds 16 characters, and with queue mode off it holds one. A pop removes the head character. A pop on an empty queue does nothing.
- R8: A character that arrives while the queue is full, with no pop in that cycle, is dropped and sets `stat_overrun_o`. A status read clears it.
- R9: `stat_fifo_err_o` sets when a character with any error tag enters the queue. A status read clears it only if no tagged character remains in the queue. It reads 0 while queue mode is off.
- R10: After reset all status outputs and `head_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | One-cycle pulse at sixteen times the bit rate |
| fifo_en_i | input | 1 | 1 selects the 16-entry queue, 0 selects a single holding slot |
| stat_rd_i | input | 1 | Status read strobe |
| pop_i | input | 1 | Removes the head character |
| head_data_o | output | 8 | Data of the head character |
| head_valid_o | output | 1 | Queue is not empty |
| stat_frame_o | output | 1 | Framing tag of the head character |
| stat_parity_o | output | 1 | Parity tag of the head character |
| stat_break_o | output | 1 | Break tag of the head character |
| stat_overrun_o | output | 1 | A character was dropped for lack of room |
| stat_fifo_err_o | output | 1 | Some tagged character has entered the queue since the last clearing read |

## Verification
Two events can fall in the same cycle: a status read, and a new character reaching the head of an empty queue. The bench holds the read strobe high for a whole frame while a character with a parity error arrives. The tags must then show for exactly one cycle before the held read clears them. The summary flag must stay set, because the tagged character is still queued. A behavioural model that keeps the queue as a list of tagged entries predicts every output on every clock. It treats a same-cycle read and head change as the head change winning.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int unsigned CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              par;
        logic              frm;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OVERSAMPLE  = 16,
    parameter bit          PARITY_EN   = 1'b1,
    parameter bit          PARITY_ODD  = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rxd_i,
    input  logic     tick_i,
    output logic     push_o,
    output rx_char_t char_o
);
    localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
    localparam int unsigned IDX_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] MID     = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CHAR_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] sh;
        logic              parbit;
        logic              push;
        rx_char_t          chr;
    } deser_t;

    deser_t q, d;
    logic [SYNC_STAGES-1:0] sync_q;
    logic rx, brk_hit, par_bad;

    // Metastability filter on the asynchronous line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
    end
    assign rx = sync_q[SYNC_STAGES-1];

    assign brk_hit = (q.sh == '0) && !rx && (!PARITY_EN || !q.parbit);
    assign par_bad = PARITY_EN && ((^q.sh ^ q.parbit) != PARITY_ODD);

    always_comb begin
        d      = q;
        d.push = 1'b0;
        if (tick_i) begin
            unique case (q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rx ? RX_IDLE : RX_DATA;
                    end else d.cnt = q.cnt + 1'b1;
                end
                RX_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sh  = {rx, q.sh[CHAR_W-1:1]};
                        if (q.idx == TOP_IDX) d.st = PARITY_EN ? RX_PAR : RX_STOP;
                        else                  d.idx = q.idx + 1'b1;
                    end else d.cnt = q.cnt + 1'b1;
                end
                RX_PAR: begin
                    if (q.cnt == LAST) begin
                        d.cnt    = '0;
                        d.parbit = rx;
                        d.st     = RX_STOP;
                    end else d.cnt = q.cnt + 1'b1;
                end
                RX_STOP: begin
                    if (q.cnt == LAST) begin
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.push = 1'b1;
                        d.chr  = '0;
                        if (brk_hit) begin
                            d.chr.brk = 1'b1;
                            d.st      = RX_HOLD;
                        end else begin
                            d.chr.par  = par_bad;
                            d.chr.frm  = !rx;
                            d.chr.data = q.sh;
                            // a low stop bit doubles as the next start bit
                            d.st       = rx ? RX_IDLE : RX_DATA;
                        end
                    end else d.cnt = q.cnt + 1'b1;
                end
                RX_HOLD: begin
                    if (rx) d.st = RX_IDLE;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push_o = q.push;
    assign char_o = q.chr;

    assert_glitch_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && tick_i && q.cnt == MID && rx) |=> (q.st == RX_IDLE && !push_o));

    assert_break_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && char_o.brk) |-> (char_o.data == '0 && !char_o.frm && !char_o.par));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       single_i,
    input  logic                       push_i,
    input  logic [WIDTH-1:0]           din_i,
    input  logic                       pop_i,
    output logic [WIDTH-1:0]           dout_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       accept_o,
    output logic                       popped_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic full;

    assign full     = single_i ? (q.cnt != '0) : (q.cnt == CW'(DEPTH));
    assign popped_o = pop_i && (q.cnt != '0);
    assign accept_o = push_i && (!full || popped_o);

    always_comb begin
        d = q;
        if (accept_o) d.wp = (q.wp == PTR_LAST) ? '0 : q.wp + 1'b1;
        if (popped_o) d.rp = (q.rp == PTR_LAST) ? '0 : q.rp + 1'b1;
        d.cnt = q.cnt + CW'(accept_o) - CW'(popped_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept_o) mem[q.wp] <= din_i;
    end

    assign dout_o  = mem[q.rp];
    assign count_o = q.cnt;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    assert_drop_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !accept_o) |=> $stable(q.cnt));
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned OVERSAMPLE = 16,
    parameter bit          PARITY_EN  = 1'b1,
    parameter bit          PARITY_ODD = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd_i,
    input  logic        tick16_i,
    input  logic        fifo_en_i,
    input  logic        stat_rd_i,
    input  logic        pop_i,
    output logic [7:0]  head_data_o,
    output logic        head_valid_o,
    output logic        stat_frame_o,
    output logic        stat_parity_o,
    output logic        stat_break_o,
    output logic        stat_overrun_o,
    output logic        stat_fifo_err_o
);
    localparam int unsigned ENTRY_W = $bits(rx_char_t);
    localparam int unsigned CW      = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [2:0]    vis;   // {brk, par, frm} visibility of head tags
        logic          ovr;
        logic          sum;
        logic [CW-1:0] errs;  // tagged entries held in the queue
    } stat_t;

    stat_t s_q, s_d;
    rx_char_t push_chr, head_chr;
    logic push, accept, popped, new_head, err_in, err_out;
    logic [ENTRY_W-1:0] fifo_dout;
    logic [CW-1:0] fifo_cnt;

    uart_rx_deser #(
        .SYNC_STAGES(2),
        .OVERSAMPLE (OVERSAMPLE),
        .PARITY_EN  (PARITY_EN),
        .PARITY_ODD (PARITY_ODD)
    ) i_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_i  (rxd_i),
        .tick_i (tick16_i),
        .push_o (push),
        .char_o (push_chr)
    );

    uart_rx_fifo #(
        .DEPTH(DEPTH),
        .WIDTH(ENTRY_W)
    ) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .single_i (!fifo_en_i),
        .push_i   (push),
        .din_i    (push_chr),
        .pop_i    (pop_i),
        .dout_o   (fifo_dout),
        .count_o  (fifo_cnt),
        .accept_o (accept),
        .popped_o (popped)
    );

    assign head_chr = rx_char_t'(fifo_dout);
    assign new_head = popped ? (fifo_cnt >= CW'(2) || accept) : (accept && fifo_cnt == '0);
    assign err_in   = accept && (push_chr.brk || push_chr.par || push_chr.frm);
    assign err_out  = popped && (head_chr.brk || head_chr.par || head_chr.frm);

    always_comb begin
        s_d      = s_q;
        s_d.errs = s_q.errs + CW'(err_in) - CW'(err_out);
        if (new_head)       s_d.vis = 3'b111;
        else if (stat_rd_i) s_d.vis = 3'b000;
        if (push && !accept) s_d.ovr = 1'b1;
        else if (stat_rd_i)  s_d.ovr = 1'b0;
        if (stat_rd_i) s_d.sum = err_in || (s_d.errs != '0);
        else           s_d.sum = s_q.sum || err_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_valid_o    = fifo_cnt != '0;
    assign head_data_o     = head_chr.data;
    assign stat_frame_o    = head_valid_o && s_q.vis[0] && head_chr.frm;
    assign stat_parity_o   = head_valid_o && s_q.vis[1] && head_chr.par;
    assign stat_break_o    = head_valid_o && s_q.vis[2] && head_chr.brk;
    assign stat_overrun_o  = s_q.ovr;
    assign stat_fifo_err_o = s_q.sum && fifo_en_i;

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !accept) |=> stat_overrun_o);

    assert_summary_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.errs != '0 && fifo_en_i) |-> stat_fifo_err_o);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !new_head) |=> !(stat_frame_o || stat_parity_o || stat_break_o));
endmodule

// File: tb/test_uart_rx_errfifo.sv
module test_uart_rx_errfifo;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b0, fifo_en = 1'b1, stat_rd = 1'b0, pop = 1'b0;
    logic [7:0] head_data;
    logic head_valid, s_frm, s_par, s_brk, s_ovr, s_sum;

    uart_rx_errfifo i_uart_rx_errfifo (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick16), .fifo_en_i(fifo_en),
        .stat_rd_i(stat_rd), .pop_i(pop), .head_data_o(head_data), .head_valid_o(head_valid),
        .stat_frame_o(s_frm), .stat_parity_o(s_par), .stat_break_o(s_brk),
        .stat_overrun_o(s_ovr), .stat_fifo_err_o(s_sum)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // tick every fourth clock, driven on the falling edge
    int tdiv = 0;
    initial forever begin
        @(negedge clk);
        tick16 = (tdiv == 3);
        tdiv   = (tdiv + 1) % 4;
    end

    // ---------------- behavioural reference model ----------------
    logic [10:0] mq[$];            // {brk, par, frm, data}
    logic [2:0]  m_vis;
    logic        m_ovr, m_sum, m_pend;
    logic [10:0] m_pval;
    int          rx_mode, rx_n, kb, cnt, errs;
    logic [10:0] rx_bits;
    logic [7:0]  dv;
    bit          do_pop, acc, nh, errp;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_vis = 0; m_ovr = 0; m_sum = 0; m_pend = 0; m_pval = 0;
            rx_mode = 0; rx_n = 0; rx_bits = 0;
        end else begin
            cnt    = mq.size();
            do_pop = pop && cnt > 0;
            acc    = m_pend && ((cnt - (do_pop ? 1 : 0)) < (fifo_en ? 16 : 1));
            nh     = do_pop ? (cnt >= 2 || acc) : (acc && cnt == 0);
            errp   = acc && (m_pval[10:8] != 0);
            if (do_pop) void'(mq.pop_front());
            if (acc) mq.push_back(m_pval);
            if (nh) m_vis = 3'b111; else if (stat_rd) m_vis = 3'b000;
            if (m_pend && !acc) m_ovr = 1; else if (stat_rd) m_ovr = 0;
            errs = 0;
            foreach (mq[i]) if (mq[i][10:8] != 0) errs++;
            if (stat_rd) m_sum = errp || (errs > 0); else m_sum = m_sum || errp;
            m_pend = 0;
            if (tick16) begin
                case (rx_mode)
                    0: if (!rxd) begin rx_mode = 1; rx_n = 0; end
                    1: begin
                        rx_n++;
                        if (rx_n == 8 && rxd) rx_mode = 0;
                        else if (rx_n >= 8 && (rx_n - 8) % 16 == 0) begin
                            kb = (rx_n - 8) / 16;
                            rx_bits[kb] = rxd;
                            if (kb == 10) begin
                                dv = rx_bits[8:1];
                                m_pend = 1;
                                if (dv == 0 && !rx_bits[9] && !rx_bits[10]) begin
                                    m_pval = {3'b100, 8'h00};
                                    rx_mode = 2;
                                end else begin
                                    m_pval = {1'b0, ^dv ^ rx_bits[9], ~rx_bits[10], dv};
                                    if (rx_bits[10]) rx_mode = 0; else rx_n = 8;
                                end
                            end
                        end
                    end
                    default: if (rxd) rx_mode = 0;
                endcase
            end
        end
    end

    // per-clock comparison, away from both edges
    always @(negedge clk) begin
        logic v;
        logic [10:0] h;
        #1;
        if (!done) begin
            v = mq.size() != 0;
            h = v ? mq[0] : 11'h0;
            chk("R7", "head_valid_o", head_valid, v);
            if (v) chk("R2", "head_data_o", head_data, h[7:0]);
            chk("R4", "stat_frame_o", s_frm, v & m_vis[0] & h[8]);
            chk("R3", "stat_parity_o", s_par, v & m_vis[1] & h[9]);
            chk("R5", "stat_break_o", s_brk, v & m_vis[2] & h[10]);
            chk("R8", "stat_overrun_o", s_ovr, m_ovr);
            chk("R9", "stat_fifo_err_o", s_sum, m_sum & fifo_en);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic align();
        @(posedge clk);
        while (!tick16) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold_line(logic v, int nt);
        rxd = v;
        for (int i = 0; i < nt; i++) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send(logic [7:0] data, logic pbit, logic stop, bit with_start);
        if (with_start) begin
            align();
            hold_line(1'b0, 16);
        end
        for (int b = 0; b < 8; b++) hold_line(data[b], 16);
        hold_line(pbit, 16);
        hold_line(stop, 16);
    endtask

    task automatic idle(int nbits);
        align();
        hold_line(1'b1, 16 * nbits);
    endtask

    task automatic rd_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        #1;
        chk("R10", "status after reset", {head_valid, s_frm, s_par, s_brk, s_ovr, s_sum}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2 clean characters
        send(8'hA5, ^8'hA5, 1'b1, 1'b1);
        send(8'h3C, ^8'h3C, 1'b1, 1'b1);
        idle(2);
        pop_one(); pop_one();

        // R3 parity error; R9 summary survives a read while still queued
        send(8'h81, ~^8'h81, 1'b1, 1'b1);
        idle(2);
        rd_status();
        #1 chk("R9", "summary held while tagged char queued", s_sum, 1);
        pop_one(); rd_status();
        #1 chk("R9", "summary cleared after drain", s_sum, 0);

        // R4 framing error with resync on the low stop bit
        send(8'h55, ^8'h55, 1'b0, 1'b1);
        send(8'h0F, ^8'h0F, 1'b1, 1'b0);
        idle(3);
        #1 chk("R4", "frame tag on head", s_frm, 1);
        pop_one(); rd_status();
        #1 chk("R4", "resynced char data", head_data, 8'h0F);
        pop_one();

        // R5 break then release
        align();
        hold_line(1'b0, 16 * 14);
        hold_line(1'b1, 32);
        #1 chk("R5", "break char data", head_data, 8'h00);
        pop_one(); rd_status();

        // R1 short glitch on an idle line
        align();
        hold_line(1'b0, 4);
        hold_line(1'b1, 48);
        #1 chk("R1", "glitch leaves queue empty", head_valid, 0);

        // R6 status read held across the arrival of a tagged character
        @(negedge clk); stat_rd = 1'b1;
        send(8'h42, ~^8'h42, 1'b1, 1'b1);
        idle(1);
        @(negedge clk); stat_rd = 1'b0;
        #1 chk("R6", "tags cleared by held read", {s_frm, s_par, s_brk}, 0);
        pop_one(); rd_status();

        // R7/R8 fill the 16-entry queue and overrun it
        for (int i = 0; i < 17; i++) send(8'(i * 7 + 1), ^(8'(i * 7 + 1)), 1'b1, 1'b1);
        idle(2);
        #1 chk("R8", "overrun after 17 arrivals", s_ovr, 1);
        rd_status();
        for (int i = 0; i < 16; i++) pop_one();
        #1 chk("R7", "queue drained", head_valid, 0);

        // R9 single-slot mode: summary masked, overrun on second arrival
        @(negedge clk); fifo_en = 1'b0;
        send(8'hC3, ~^8'hC3, 1'b1, 1'b1);
        send(8'h11, ^8'h11, 1'b1, 1'b1);
        idle(2);
        #1 chk("R9", "summary masked with queue off", s_sum, 0);
        pop_one(); rd_status();
        @(negedge clk); fifo_en = 1'b1;
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule